// File: doc/BRIEF.md
# Dual-Width Binary/Decimal Accumulator Adder

This unit performs the arithmetic step for an accumulator. It supports add with carry, subtract with borrow and compare, in either a byte-wide or a word-wide mode. Addition can run in binary or in packed decimal, where every four-bit group holds one decimal digit. The unit takes the accumulator, an operand, a carry input, a decimal-mode flag and a width flag. It returns the new accumulator value and the negative, overflow, zero and carry flags.

Inputs are captured on a clock edge while `inValid` is high. The results appear on the outputs one cycle later and stay there until the next captured operation. In byte mode only the low byte of the accumulator takes the sum, and the high byte passes through unchanged. A compare never alters the accumulator. Decimal subtraction is not supported: it raises an error flag, and its result is left unspecified.

Top module: `bcd_alu`

## Requirements
- R1: While reset is held, and after it is released until the first captured operation, every output is 0.
- R2: With op=00 (add), binary mode and word width, `result` is the low 16 bits of acc+operand+carryIn, and `flagC` is bit 16 of that sum.
- R3: With op=00, binary mode and byte width, `result[7:0]` is the low 8 bits of acc[7:0]+operand[7:0]+carryIn, `flagC` is bit 8 of that sum, and `result[15:8]` equals acc[15:8].
- R4: With op=01 (subtract) in binary mode, the unit adds the one's complement of the operand together with carryIn. `flagC`=1 means no borrow occurred. Result and carry are taken as in R2 and R3 for the chosen width.
- R5: After add or subtract, `flagV` is bit s of (R xor acc) and (R xor B'). Here R is the width result, B' is the operand as it was added (inverted for subtract), and s is 15 in word width or 7 in byte width.
- R6: After add or subtract, `flagN` is bit s of the result. `flagZ` is 1 exactly when the result masked to the width is zero.
- R7: With op=00 and decimal=1, digits are added from the least significant upward, each together with the running carry. A digit sum of 10 or more has 6 added, is kept to four bits and carries 1 into the next digit. `flagC` is the carry out of digit 1 in byte width or digit 3 in word width. For operands made of valid digits, the result is the decimal sum modulo 100 or 10000.
- R8: With op[1]=1 (compare, codes 10 and 11), acc minus operand is computed in binary with carry forced to 1, whatever the decimal and carryIn inputs are. `result` equals acc. `flagC` is 1 when acc ≥ operand as unsigned values of the width. `flagN` and `flagZ` follow the difference as in R6, and `flagV` keeps its previous value.
- R9: `errFlag` is 1 after an operation with op=01 and decimal=1, and 0 after any other operation.
- R10: `outValid` is 1 in the cycle after each capture and 0 otherwise. Without a capture, `result` and all flags hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Capture the operation on this edge |
| op | input | 2 | 00 add, 01 subtract, 1x compare |
| decimal | input | 1 | Packed-decimal mode for add |
| wide | input | 1 | 1 word width, 0 byte width |
| acc | input | 16 | Accumulator value |
| opnd | input | 16 | Operand |
| carryIn | input | 1 | Incoming carry |
| outValid | output | 1 | Result registered this cycle |
| result | output | 16 | New accumulator value |
| flagN | output | 1 | Negative flag |
| flagV | output | 1 | Overflow flag |
| flagZ | output | 1 | Zero flag |
| flagC | output | 1 | Carry / no-borrow flag |
| errFlag | output | 1 | Unsupported decimal subtract |

## Verification
The decimal-digit property assumes that both operands of a decimal add hold only digits 0 to 9. The bench's decimal stimulus is built from such digits, either by sweeping every byte-wide pair or by drawing each digit modulo ten. The other properties assume that reset is asserted from time zero. They make no assumption about operand values, so the binary sweeps use arbitrary high bytes to expose any leakage into the preserved upper half. Compares are driven with random decimal and carry inputs, which shows that these inputs are ignored.

// File: rtl/bcd_alu_pkg.sv
package bcd_alu_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_CMP  = 2'b10,
    OP_CMPA = 2'b11
  } aluOp_t;

  typedef struct packed {
    logic invOperand;
    logic forceCarry;
    logic decimalAdd;
    logic wide;
    logic writeAcc;
    logic updV;
    logic errRaise;
  } aluStrobes_t;
endpackage

// File: rtl/bcd_alu_ctrl.sv
module bcd_alu_ctrl
  import bcd_alu_pkg::*;
(
  input  logic [1:0]  op,
  input  logic        decimal,
  input  logic        wide,
  output aluStrobes_t strobes
);
  logic isCmp;
  logic isSub;

  assign isCmp = op[1];
  assign isSub = (op == OP_SUB);

  always_comb begin
    strobes            = '0;
    strobes.invOperand = isCmp | isSub;
    strobes.forceCarry = isCmp;
    strobes.decimalAdd = decimal & (op == OP_ADD);
    strobes.wide       = wide;
    strobes.writeAcc   = ~isCmp;
    strobes.updV       = ~isCmp;
    strobes.errRaise   = decimal & isSub;
  end
endmodule

// File: rtl/bcd_alu_dpath.sv
module bcd_alu_dpath
  import bcd_alu_pkg::*;
#(
  parameter int WORD_W = 16
)(
  input  logic [WORD_W-1:0] acc,
  input  logic [WORD_W-1:0] opnd,
  input  logic              carryIn,
  input  aluStrobes_t       strobes,
  output logic [WORD_W-1:0] nextResult,
  output logic              nextN,
  output logic              nextV,
  output logic              nextZ,
  output logic              nextC
);
  localparam int NIB  = WORD_W / 4;
  localparam int HALF = WORD_W / 2;

  logic [WORD_W-1:0] addend;
  logic              carryEff;
  logic [WORD_W:0]   fullSum;
  logic [HALF:0]     lowSum;
  logic [NIB:0]      digitCarry;
  logic [WORD_W-1:0] decWord;
  logic [WORD_W-1:0] sumWord;
  logic [WORD_W-1:0] mergeWord;
  logic [WORD_W-1:0] ovVec;

  assign addend   = strobes.invOperand ? ~opnd : opnd;
  assign carryEff = strobes.forceCarry ? 1'b1 : carryIn;

  assign fullSum = {1'b0, acc} + {1'b0, addend} + {{WORD_W{1'b0}}, carryEff};
  assign lowSum  = {1'b0, acc[HALF-1:0]} + {1'b0, addend[HALF-1:0]}
                 + {{HALF{1'b0}}, carryEff};

  // Decimal digit chain, least significant digit first.
  assign digitCarry[0] = carryEff;
  for (genvar i = 0; i < NIB; i++) begin : g_digit
    logic [4:0] rawSum;
    logic       overTen;
    assign rawSum  = {1'b0, acc[4*i +: 4]} + {1'b0, opnd[4*i +: 4]}
                   + {4'b0000, digitCarry[i]};
    assign overTen = (rawSum >= 5'd10);
    assign decWord[4*i +: 4] = overTen ? (rawSum[3:0] + 4'd6) : rawSum[3:0];
    assign digitCarry[i+1]   = overTen;
  end

  assign sumWord   = strobes.decimalAdd ? decWord : fullSum[WORD_W-1:0];
  assign mergeWord = strobes.wide ? sumWord : {acc[WORD_W-1:HALF], sumWord[HALF-1:0]};
  assign ovVec     = (sumWord ^ acc) & (sumWord ^ addend);

  always_comb begin
    if (strobes.decimalAdd)
      nextC = strobes.wide ? digitCarry[NIB] : digitCarry[NIB/2];
    else
      nextC = strobes.wide ? fullSum[WORD_W] : lowSum[HALF];
    nextN      = strobes.wide ? sumWord[WORD_W-1] : sumWord[HALF-1];
    nextV      = strobes.wide ? ovVec[WORD_W-1] : ovVec[HALF-1];
    nextZ      = strobes.wide ? ~|sumWord : ~|sumWord[HALF-1:0];
    nextResult = strobes.writeAcc ? mergeWord : acc;
  end
endmodule

// File: rtl/bcd_alu.sv
module bcd_alu
  import bcd_alu_pkg::*;
#(
  parameter int WORD_W = 16
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic [1:0]        op,
  input  logic              decimal,
  input  logic              wide,
  input  logic [WORD_W-1:0] acc,
  input  logic [WORD_W-1:0] opnd,
  input  logic              carryIn,
  output logic              outValid,
  output logic [WORD_W-1:0] result,
  output logic              flagN,
  output logic              flagV,
  output logic              flagZ,
  output logic              flagC,
  output logic              errFlag
);
  localparam int HALF = WORD_W / 2;
  localparam int NIB  = WORD_W / 4;

  aluStrobes_t       strobes;
  logic [WORD_W-1:0] nextResult;
  logic              nextN, nextV, nextZ, nextC;

  bcd_alu_ctrl u_ctrl (
    .op      (op),
    .decimal (decimal),
    .wide    (wide),
    .strobes (strobes)
  );

  bcd_alu_dpath #(.WORD_W(WORD_W)) u_dpath (
    .acc        (acc),
    .opnd       (opnd),
    .carryIn    (carryIn),
    .strobes    (strobes),
    .nextResult (nextResult),
    .nextN      (nextN),
    .nextV      (nextV),
    .nextZ      (nextZ),
    .nextC      (nextC)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      result   <= '0;
      flagN    <= 1'b0;
      flagV    <= 1'b0;
      flagZ    <= 1'b0;
      flagC    <= 1'b0;
      errFlag  <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        result  <= nextResult;
        flagN   <= nextN;
        flagZ   <= nextZ;
        flagC   <= nextC;
        errFlag <= strobes.errRaise;
        if (strobes.updV) flagV <= nextV;
      end
    end
  end

  function automatic logic digitsOk(input logic [WORD_W-1:0] x, input logic w);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < NIB; i++)
      if ((w || i < NIB/2) && x[4*i +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  // R10: outputs hold without a capture
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> $stable(result) && $stable(flagC) && $stable(flagN)
                 && $stable(flagZ) && $stable(flagV) && !outValid);

  p_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);

  // R8: compare leaves accumulator and overflow untouched
  p_cmp_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && op[1] |=> (result == $past(acc)) && $stable(flagV));

  // R3: byte width keeps the high byte
  p_high_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && !wide |=> result[WORD_W-1:HALF] == $past(acc[WORD_W-1:HALF]));

  // R9: error only for decimal subtract
  p_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> errFlag == $past(decimal && op == 2'b01));

  // R6: zero and sign follow the width result
  p_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && !op[1] |=>
      flagZ == ($past(wide) ? (result == '0) : (result[HALF-1:0] == '0)));

  p_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && !op[1] |=>
      flagN == ($past(wide) ? result[WORD_W-1] : result[HALF-1]));

  // R7: valid digits in give valid digits out
  p_bcd_digits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && decimal && op == 2'b00 && digitsOk(acc, 1'b1) && digitsOk(opnd, 1'b1)
      |=> digitsOk(result, $past(wide)));
endmodule

// File: tb/sim_bcd_alu.sv
`timescale 1ns/1ps
module sim_bcd_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  op = 2'b00;
  logic        decimal = 1'b0;
  logic        wide = 1'b0;
  logic [15:0] acc = '0;
  logic [15:0] opnd = '0;
  logic        carryIn = 1'b0;
  logic        outValid;
  logic [15:0] result;
  logic        flagN, flagV, flagZ, flagC, errFlag;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [31:0] rng = 32'h1234_5679;
  logic vPrev = 1'b0;
  bit   vKnown = 1'b1;

  always #2 clk = ~clk;

  bcd_alu #(.WORD_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .op(op), .decimal(decimal),
    .wide(wide), .acc(acc), .opnd(opnd), .carryIn(carryIn), .outValid(outValid),
    .result(result), .flagN(flagN), .flagV(flagV), .flagZ(flagZ), .flagC(flagC),
    .errFlag(errFlag)
  );

  function automatic logic [31:0] nextRand(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic stepRand();
    rng = nextRand(rng);
  endtask

  function automatic int bcdToInt(input logic [15:0] x, input int n);
    int v;
    v = 0;
    for (int i = n - 1; i >= 0; i--) v = v * 10 + int'(x[4*i +: 4]);
    return v;
  endfunction

  function automatic logic [15:0] intToBcd(input int v, input int n);
    logic [15:0] r;
    int t;
    r = '0;
    t = v;
    for (int i = 0; i < n; i++) begin
      r[4*i +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  function automatic logic [15:0] randBcd();
    logic [15:0] r;
    logic [31:0] s;
    s = rng;
    for (int i = 0; i < 4; i++) begin
      r[4*i +: 4] = 4'(s[8*i +: 8] % 10);
    end
    return r;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic runVec(input logic [1:0] o, input logic d, input logic w,
                        input logic [15:0] a, input logic [15:0] b, input logic c);
    logic [15:0] bb, r, ov, lowDec, expR;
    logic        ce, cc, en, ez, ev;
    bit          isCmp, isErr;
    int          s, sb;
    string       tag;
    isCmp = o[1];
    isErr = d && (o == 2'b01);
    bb = (o == 2'b00) ? b : ~b;
    ce = isCmp ? 1'b1 : c;
    sb = w ? 15 : 7;
    if (d && o == 2'b00) begin
      if (w) begin
        s = bcdToInt(a, 4) + bcdToInt(b, 4) + int'(c);
        cc = (s >= 10000);
        r = intToBcd(s % 10000, 4);
      end else begin
        s = bcdToInt(a, 2) + bcdToInt(b, 2) + int'(c);
        cc = (s >= 100);
        lowDec = intToBcd(s % 100, 2);
        r = {a[15:8], lowDec[7:0]};
      end
    end else begin
      if (w) begin
        s = int'(a) + int'(bb) + int'(ce);
        r = s[15:0];
        cc = s[16];
      end else begin
        s = int'(a[7:0]) + int'(bb[7:0]) + int'(ce);
        r = {a[15:8], s[7:0]};
        cc = s[8];
      end
    end
    ov = (r ^ a) & (r ^ bb);
    ev = ov[sb];
    en = r[sb];
    ez = w ? (r == 16'h0) : (r[7:0] == 8'h0);
    expR = isCmp ? a : r;
    if (isErr) tag = "R9";
    else if (isCmp) tag = "R8";
    else if (d) tag = "R7";
    else if (o == 2'b01) tag = "R4";
    else if (w) tag = "R2";
    else tag = "R3";

    op = o; decimal = d; wide = w; acc = a; opnd = b; carryIn = c; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    chk("R10", "outValid", int'(outValid), 1);
    chk("R9", "errFlag", int'(errFlag), int'(isErr));
    if (isErr) begin
      vKnown = 1'b0;
    end else begin
      chk(tag, "result", int'(result), int'(expR));
      chk(tag, "carry", int'(flagC), int'(cc));
      chk("R6", "neg", int'(flagN), int'(en));
      chk("R6", "zero", int'(flagZ), int'(ez));
      if (isCmp) begin
        if (vKnown) chk("R8", "vHeld", int'(flagV), int'(vPrev));
      end else begin
        chk("R5", "overflow", int'(flagV), int'(ev));
        vPrev = ev;
        vKnown = 1'b1;
      end
    end
  endtask

  task automatic holdCheck();
    logic [15:0] r0;
    logic c0, n0, z0, v0;
    r0 = result; c0 = flagC; n0 = flagN; z0 = flagZ; v0 = flagV;
    stepRand();
    acc = rng[15:0]; opnd = rng[31:16]; op = rng[1:0]; carryIn = rng[5];
    inValid = 1'b0;
    @(negedge clk);
    chk("R10", "holdResult", int'(result), int'(r0));
    chk("R10", "holdFlags", int'({flagC, flagN, flagZ, flagV}), int'({c0, n0, z0, v0}));
    chk("R10", "outValidLow", int'(outValid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "resetResult", int'(result), 0);
    chk("R1", "resetFlags", int'({outValid, flagN, flagV, flagZ, flagC, errFlag}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "postReset", int'({outValid, result, flagN, flagV, flagZ, flagC, errFlag}), 0);

    // Corner cases
    runVec(2'b00, 1'b0, 1'b1, 16'hFFFF, 16'h0000, 1'b1);  // R2 wrap, carry, zero
    runVec(2'b00, 1'b0, 1'b1, 16'h7FFF, 16'h0001, 1'b0);  // R5 signed overflow
    runVec(2'b00, 1'b0, 1'b0, 16'hAB7F, 16'h5501, 1'b0);  // R3 byte overflow, high kept
    holdCheck();
    runVec(2'b01, 1'b0, 1'b1, 16'h0000, 16'h0001, 1'b1);  // R4 borrow
    runVec(2'b00, 1'b1, 1'b1, 16'h9999, 16'h0000, 1'b1);  // R7 full decimal carry
    runVec(2'b00, 1'b1, 1'b0, 16'h1299, 16'h0001, 1'b0);  // R7 byte decimal carry
    runVec(2'b10, 1'b1, 1'b1, 16'h1234, 16'h1234, 1'b0);  // R8 equal compare
    runVec(2'b11, 1'b0, 1'b0, 16'hFF10, 16'h0020, 1'b1);  // R8 alternate code
    runVec(2'b01, 1'b1, 1'b0, 16'h0050, 16'h0020, 1'b1);  // R9 unsupported
    runVec(2'b00, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b0);
    holdCheck();

    // Byte-width binary sweeps: add, subtract, compare
    for (int o = 0; o < 3; o++) begin
      for (int a = 0; a < 256; a += 3) begin
        for (int b = 0; b < 256; b += 11) begin
          for (int c = 0; c < 2; c++) begin
            stepRand();
            if (o == 2)
              runVec(rng[7] ? 2'b11 : 2'b10, rng[9], 1'b0,
                     {rng[15:8], 8'(a)}, {rng[23:16], 8'(b)}, 1'(c));
            else
              runVec(2'(o), 1'b0, 1'b0, {rng[15:8], 8'(a)}, {rng[23:16], 8'(b)}, 1'(c));
          end
        end
      end
    end
    holdCheck();

    // Byte-width decimal: every digit pair
    for (int a = 0; a < 100; a++) begin
      for (int b = 0; b < 100; b++) begin
        for (int c = 0; c < 2; c++) begin
          stepRand();
          runVec(2'b00, 1'b1, 1'b0, {rng[15:8], intToBcd(a, 2)[7:0]},
                 {rng[23:16], intToBcd(b, 2)[7:0]}, 1'(c));
        end
      end
    end

    // Word width, random
    for (int k = 0; k < 3000; k++) begin
      logic [15:0] ra, rb;
      stepRand(); ra = rng[15:0]; rb = rng[31:16];
      stepRand();
      runVec(2'b00, 1'b0, 1'b1, ra, rb, rng[0]);
      runVec(2'b01, 1'b0, 1'b1, rb, ra, rng[1]);
      runVec({1'b1, rng[2]}, rng[3], 1'b1, ra, rb, rng[4]);
      stepRand(); ra = randBcd();
      stepRand(); rb = randBcd();
      runVec(2'b00, 1'b1, 1'b1, ra, rb, rng[0]);
    end
    holdCheck();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule